// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a two-level page table held in memory. The walk starts from a root register that holds the frame number of the directory. The walker takes one request at a time. A request carries the linear address, a write flag and a user-mode flag. The walker reads the directory entry and then the table entry, and checks each entry's present, write and user flags. It writes back the accessed and dirty flags only after both levels have passed their checks. It then reports either a physical address or a page fault, together with the fault details.

The memory port carries one transaction at a time. `mem_req` stays high, with a stable address, write enable and write data, until the memory returns a one-cycle `mem_ack`. For a read, `mem_rdata` must be valid in that ack cycle. The root register is loaded through its own write port, and software writes it while the walker is idle.

The walker is built around one state machine with these states:
- `S_IDLE`: waits for a request and has `req_ready` high.
- `S_RD_DIR` and `S_RD_TBL`: read the directory entry and the table entry.
- `S_CHK_DIR` and `S_CHK_TBL`: check the entry just read.
- `S_WB_DIR` and `S_WB_TBL`: write back the flags.
- `S_RESP`: a one-cycle response.

The transitions are:
- `S_IDLE` to `S_RD_DIR` when a request is accepted.
- A read state to its check state on `mem_ack`.
- `S_CHK_DIR` to `S_RD_TBL` when the directory entry passes, or to `S_RESP` when it fails.
- `S_CHK_TBL` to `S_RESP` when the table entry fails. When it passes, it goes to `S_WB_DIR` if the directory entry needs a write, else to `S_WB_TBL` if the table entry needs one, else to `S_RESP`.
- `S_WB_DIR` to `S_WB_TBL` or `S_RESP` on `mem_ack`.
- `S_WB_TBL` to `S_RESP` on `mem_ack`.
- `S_RESP` to `S_IDLE`.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_done`, `rsp_fault` and `mem_req` are 0.
- R2: The directory entry is read at the address {root frame, linear[31:22], 2'b00}. The table entry is read at {directory entry[31:12], linear[21:12], 2'b00}. While `mem_req` waits for `mem_ack`, the address does not change.
- R3: A successful walk gives one `rsp_done` pulse with `rsp_fault` = 0 and `rsp_paddr` = {table entry[31:12], linear[11:0]}.
- R4: The present flag is bit 0 of an entry. If it is clear at either level, the walk faults with `rsp_present` = 0. When the directory entry is not present, the table is not read.
- R5: The user flag is bit 2 of an entry. A user-mode access faults with `rsp_present` = 1 if the user flag is clear at either level.
- R6: The write flag is bit 1 of an entry. A write access faults if the write flag is clear at either level. This applies in supervisor mode too.
- R7: The accessed flag is bit 5 of an entry. On success, each level's entry whose accessed flag was clear is rewritten as the original entry with bit 5 set. An entry whose accessed flag was already set is not written.
- R8: The dirty flag is bit 6 of an entry. It is set in the table entry only on a successful write access. A read never sets it, and it is never set in a directory entry.
- R9: A faulting walk performs no memory write. Both entries keep their contents.
- R10: With `rsp_done`, the outputs `rsp_vaddr`, `rsp_write` and `rsp_user` report the request's linear address, write flag and user flag.
- R11: `req_ready` is low from the cycle after a request is accepted until `rsp_done`. A `req_valid` raised while the walker is busy is ignored and starts no walk.
- R12: A supervisor read succeeds even when the user and write flags are clear at both levels.
- R13: A value written through `root_we` and `root_frame` becomes the directory base for the walks that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load the root register |
| root_frame | input | 20 | Frame number of the page directory |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle; a request is accepted this cycle |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | The access is a write |
| req_user | input | 1 | The access is made in user mode |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | The transaction is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | One-cycle completion of the transaction |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | The walk faulted |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_vaddr | output | 32 | Linear address of the request |
| rsp_present | output | 1 | The last entry checked was present |
| rsp_write | output | 1 | Write flag of the request |
| rsp_user | output | 1 | User flag of the request |

## Verification
The bench drives walks through several kinds of table content:
- **Clean entries.** The accessed flags are clear at both levels. This shows that both entries get their write-back, and shows the exact entry addresses.
- **Repeat walk.** The same address is walked again. This separates "write if clear" from "always write".
- **Write to a clean page.** This exposes the dirty update and shows that only the table entry gets it.
- **Faulting walks.** Each one clears a single flag (present, user or write) at one level. This tells apart which level raised the fault and whether the present report is right. It also shows that no write leaks out before the second check.
- **Supervisor read, busy-time request, root change.** A supervisor read of a locked-down page, a request raised while busy, and a walk after a new root value cover the remaining paths.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int FLG_P = 0;
    localparam int FLG_W = 1;
    localparam int FLG_U = 2;
    localparam int FLG_A = 5;
    localparam int FLG_D = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_DIR,
        S_CHK_DIR,
        S_RD_TBL,
        S_CHK_TBL,
        S_WB_DIR,
        S_WB_TBL,
        S_RESP
    } walk_state_t;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int FRAME_W = 20,
    parameter int IDX_W   = 10,
    parameter int ADDR_W  = 32
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [IDX_W-1:0]   index,
    output logic [ADDR_W-1:0]  addr
);
    localparam int SCALE_W = ADDR_W - FRAME_W - IDX_W;

    // table base plus index scaled by the entry size
    assign addr = {frame, index, {SCALE_W{1'b0}}};
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
#(
    parameter int ENT_W   = 32,
    parameter bit IS_LEAF = 1'b0
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    input  logic             is_user,
    output logic             present,
    output logic             allowed,
    output logic             need_wb,
    output logic [ENT_W-1:0] wb_data
);
    logic [ENT_W-1:0] set_mask;

    always_comb begin
        set_mask        = '0;
        set_mask[FLG_A] = 1'b1;
        if (IS_LEAF && is_write)
            set_mask[FLG_D] = 1'b1;
    end

    assign present = entry[FLG_P];
    assign allowed = (!is_user || entry[FLG_U]) && (!is_write || entry[FLG_W]);
    assign wb_data = entry | set_mask;
    assign need_wb = (wb_data != entry);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       root_we,
    input  logic [ADDR_W-OFFS_W-1:0]   root_frame,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_vaddr,
    input  logic                       req_write,
    input  logic                       req_user,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [ADDR_W-1:0]          mem_wdata,
    input  logic                       mem_ack,
    input  logic [ADDR_W-1:0]          mem_rdata,
    output logic                       rsp_done,
    output logic                       rsp_fault,
    output logic [ADDR_W-1:0]          rsp_paddr,
    output logic [ADDR_W-1:0]          rsp_vaddr,
    output logic                       rsp_present,
    output logic                       rsp_write,
    output logic                       rsp_user
);
    localparam int FRAME_W = ADDR_W - OFFS_W;
    localparam int IDX_W   = FRAME_W / 2;
    localparam int LEVELS  = 2;

    walk_state_t state_q, state_d;

    logic [FRAME_W-1:0] root_q;
    logic [ADDR_W-1:0]  va_q;
    logic               wr_q, us_q;
    logic [ADDR_W-1:0]  ent_q   [LEVELS];
    logic               fault_q, pres_q;
    logic [ADDR_W-1:0]  paddr_q;

    logic [FRAME_W-1:0] lvl_base [LEVELS];
    logic [IDX_W-1:0]   lvl_idx  [LEVELS];
    logic [ADDR_W-1:0]  ent_addr [LEVELS];
    logic [ADDR_W-1:0]  wb_data  [LEVELS];
    logic               pres     [LEVELS];
    logic               allow    [LEVELS];
    logic               need_wb  [LEVELS];
    logic               lvl_ok   [LEVELS];

    // per-level address and permission logic
    assign lvl_base[0] = root_q;
    assign lvl_base[1] = ent_q[0][ADDR_W-1:OFFS_W];
    assign lvl_idx[0]  = va_q[ADDR_W-1 -: IDX_W];
    assign lvl_idx[1]  = va_q[OFFS_W +: IDX_W];

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        ptw_entry_addr #(
            .FRAME_W (FRAME_W),
            .IDX_W   (IDX_W),
            .ADDR_W  (ADDR_W)
        ) u_addr (
            .frame (lvl_base[l]),
            .index (lvl_idx[l]),
            .addr  (ent_addr[l])
        );

        ptw_perm_check #(
            .ENT_W   (ADDR_W),
            .IS_LEAF (l == LEVELS - 1)
        ) u_perm (
            .entry    (ent_q[l]),
            .is_write (wr_q),
            .is_user  (us_q),
            .present  (pres[l]),
            .allowed  (allow[l]),
            .need_wb  (need_wb[l]),
            .wb_data  (wb_data[l])
        );

        assign lvl_ok[l] = pres[l] && allow[l];
    end

    // root register
    always_ff @(posedge clk) begin
        if (!rst_n)
            root_q <= '0;
        else if (root_we)
            root_q <= root_frame;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = S_RD_DIR;
            S_RD_DIR:  if (mem_ack)   state_d = S_CHK_DIR;
            S_CHK_DIR: state_d = lvl_ok[0] ? S_RD_TBL : S_RESP;
            S_RD_TBL:  if (mem_ack)   state_d = S_CHK_TBL;
            S_CHK_TBL: begin
                if (!lvl_ok[1])
                    state_d = S_RESP;
                else if (need_wb[0])
                    state_d = S_WB_DIR;
                else if (need_wb[1])
                    state_d = S_WB_TBL;
                else
                    state_d = S_RESP;
            end
            S_WB_DIR:  if (mem_ack) state_d = need_wb[1] ? S_WB_TBL : S_RESP;
            S_WB_TBL:  if (mem_ack) state_d = S_RESP;
            S_RESP:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // request capture, entry capture and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q     <= '0;
            wr_q     <= 1'b0;
            us_q     <= 1'b0;
            ent_q[0] <= '0;
            ent_q[1] <= '0;
            fault_q  <= 1'b0;
            pres_q   <= 1'b0;
            paddr_q  <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                va_q    <= req_vaddr;
                wr_q    <= req_write;
                us_q    <= req_user;
                fault_q <= 1'b0;
                pres_q  <= 1'b0;
                paddr_q <= '0;
            end
            if (state_q == S_RD_DIR && mem_ack)
                ent_q[0] <= mem_rdata;
            if (state_q == S_RD_TBL && mem_ack)
                ent_q[1] <= mem_rdata;
            if (state_q == S_CHK_DIR && !lvl_ok[0]) begin
                fault_q <= 1'b1;
                pres_q  <= pres[0];
            end
            if (state_q == S_CHK_TBL) begin
                fault_q <= !lvl_ok[1];
                pres_q  <= pres[1];
                paddr_q <= lvl_ok[1] ? {ent_q[1][ADDR_W-1:OFFS_W], va_q[OFFS_W-1:0]} : '0;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_done  = (state_q == S_RESP);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            S_RD_DIR: begin
                mem_req  = 1'b1;
                mem_addr = ent_addr[0];
            end
            S_RD_TBL: begin
                mem_req  = 1'b1;
                mem_addr = ent_addr[1];
            end
            S_WB_DIR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ent_addr[0];
                mem_wdata = wb_data[0];
            end
            S_WB_TBL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ent_addr[1];
                mem_wdata = wb_data[1];
            end
            default: ;
        endcase
    end

    assign rsp_fault   = fault_q;
    assign rsp_paddr   = paddr_q;
    assign rsp_vaddr   = va_q;
    assign rsp_present = pres_q;
    assign rsp_write   = wr_q;
    assign rsp_user    = us_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              rsp_done,
    input logic              rsp_fault,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [ADDR_W-1:0] rsp_vaddr
);
    // R2: a pending transaction holds its address and direction
    p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R3: the response strobe lasts one cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R3: a translation keeps the page offset
    p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done && !rsp_fault |-> rsp_paddr[OFFS_W-1:0] == rsp_vaddr[OFFS_W-1:0]);

    // R7: every write-back carries the accessed flag
    p_wb_accessed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[5]);

    // R11: an accepted request makes the walker busy
    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R1: no memory traffic while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);
endmodule

bind pt_walker ptw_checker #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_ptw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .rsp_done  (rsp_done),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr),
    .rsp_vaddr (rsp_vaddr)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_we = 1'b0;
    logic [19:0] root_frame = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_done, rsp_fault, rsp_present, rsp_write, rsp_user;
    logic [31:0] rsp_paddr, rsp_vaddr;

    always #2.5 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_frame(root_frame),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_vaddr(rsp_vaddr), .rsp_present(rsp_present),
        .rsp_write(rsp_write), .rsp_user(rsp_user)
    );

    // memory model: ack one cycle after a request, logs traffic
    logic [31:0] mem [0:8191];
    logic        poke_en = 1'b0;
    logic [31:0] poke_addr = '0, poke_data = '0;
    int          rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
    logic [31:0] rd_log [0:7];
    logic [31:0] wr_alog [0:7];
    logic [31:0] wr_dlog [0:7];

    always @(posedge clk) begin
        if (poke_en) mem[poke_addr[14:2]] <= poke_data;
        if (rsp_done) done_cnt <= done_cnt + 1;
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[14:2]] <= mem_wdata;
                wr_alog[wr_cnt & 7] <= mem_addr;
                wr_dlog[wr_cnt & 7] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[14:2]];
                rd_log[rd_cnt & 7] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    int total = 0, fails = 0;
    int rd0, wr0;
    logic        r_fault, r_present, r_write, r_user;
    logic [31:0] r_paddr, r_vaddr;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic wait_done();
        for (int n = 0; n < 200 && !rsp_done; n++) @(negedge clk);
        r_fault = rsp_fault; r_present = rsp_present; r_paddr = rsp_paddr;
        r_vaddr = rsp_vaddr; r_write = rsp_write; r_user = rsp_user;
        chk("R3", "done seen", {31'd0, rsp_done}, 32'd1);
        @(negedge clk);
    endtask

    task automatic walk(input logic [31:0] va, input logic w, input logic u);
        @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
    endtask

    localparam logic [31:0] VA1 = (32'd5 << 22) | (32'd7 << 12) | 32'h456;

    task automatic t_reset();
        chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1", "rsp_done", {31'd0, rsp_done}, 32'd0);
        chk("R1", "rsp_fault", {31'd0, rsp_fault}, 32'd0);
        chk("R1", "mem_req", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_first_read();
        walk(VA1, 1'b0, 1'b1);
        chk("R3", "paddr", r_paddr, 32'h0ABCD456);
        chk("R3", "fault", {31'd0, r_fault}, 32'd0);
        chk("R2", "dir addr", rd_log[rd0 & 7], 32'h00001014);
        chk("R2", "tbl addr", rd_log[(rd0 + 1) & 7], 32'h0000201C);
        chk("R7", "write count", wr_cnt - wr0, 2);
        chk("R7", "dir wb", mem[32'h1014 >> 2], 32'h00002027);
        chk("R8", "tbl wb no dirty on read", mem[32'h201C >> 2], 32'h0ABCD027);
        chk("R10", "vaddr", r_vaddr, VA1);
        chk("R10", "user", {31'd0, r_user}, 32'd1);
    endtask

    task automatic t_repeat();
        walk(VA1, 1'b0, 1'b0);
        chk("R7", "no rewrite when set", wr_cnt - wr0, 0);
        chk("R3", "paddr again", r_paddr, 32'h0ABCD456);
    endtask

    task automatic t_dirty();
        walk(VA1, 1'b1, 1'b1);
        chk("R8", "one write", wr_cnt - wr0, 1);
        chk("R8", "dirty addr", wr_alog[wr0 & 7], 32'h0000201C);
        chk("R8", "dirty data", wr_dlog[wr0 & 7], 32'h0ABCD067);
        chk("R8", "dir not dirty", mem[32'h1014 >> 2], 32'h00002027);
        chk("R10", "write flag", {31'd0, r_write}, 32'd1);
    endtask

    task automatic t_not_present();
        walk((32'd6 << 22) | 32'h123, 1'b0, 1'b0);
        chk("R4", "dir fault", {31'd0, r_fault}, 32'd1);
        chk("R4", "dir present", {31'd0, r_present}, 32'd0);
        chk("R4", "single read", rd_cnt - rd0, 1);
        chk("R9", "no write", wr_cnt - wr0, 0);
        poke(32'h2020, 32'h12345006);
        walk((32'd5 << 22) | (32'd8 << 12), 1'b1, 1'b0);
        chk("R4", "tbl fault", {31'd0, r_fault}, 32'd1);
        chk("R4", "tbl present", {31'd0, r_present}, 32'd0);
        chk("R9", "tbl unchanged", mem[32'h2020 >> 2], 32'h12345006);
        chk("R3", "paddr zero on fault", r_paddr, 32'h0);
    endtask

    task automatic t_user();
        poke(32'h1024, 32'h00003003);
        walk((32'd9 << 22) | 32'h10, 1'b0, 1'b1);
        chk("R5", "dir user fault", {31'd0, r_fault}, 32'd1);
        chk("R5", "dir present", {31'd0, r_present}, 32'd1);
        poke(32'h1028, 32'h00003007);
        poke(32'h3004, 32'h66666003);
        walk((32'd10 << 22) | (32'd1 << 12), 1'b0, 1'b1);
        chk("R5", "tbl user fault", {31'd0, r_fault}, 32'd1);
        chk("R9", "dir A not set", mem[32'h1028 >> 2], 32'h00003007);
        chk("R9", "no write", wr_cnt - wr0, 0);
    endtask

    task automatic t_write_perm();
        poke(32'h2028, 32'h77777005);
        walk((32'd5 << 22) | (32'd10 << 12), 1'b1, 1'b1);
        chk("R6", "tbl write fault", {31'd0, r_fault}, 32'd1);
        chk("R6", "present", {31'd0, r_present}, 32'd1);
        poke(32'h102C, 32'h00003005);
        walk(32'd11 << 22, 1'b1, 1'b0);
        chk("R6", "dir write fault sup", {31'd0, r_fault}, 32'd1);
        chk("R10", "fault vaddr", r_vaddr, 32'd11 << 22);
    endtask

    task automatic t_supervisor();
        poke(32'h1030, 32'h00003001);
        poke(32'h3008, 32'h88888001);
        walk(32'h03002ABC, 1'b0, 1'b0);
        chk("R12", "fault", {31'd0, r_fault}, 32'd0);
        chk("R12", "paddr", r_paddr, 32'h88888ABC);
        chk("R7", "tbl A set", mem[32'h3008 >> 2], 32'h88888021);
    endtask

    task automatic t_busy();
        int d0;
        @(negedge clk);
        rd0 = rd_cnt; d0 = done_cnt;
        req_vaddr = VA1; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        chk("R11", "busy ready", {31'd0, req_ready}, 32'd0);
        req_vaddr = 32'h03002ABC;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (8) @(negedge clk);
        chk("R11", "paddr of first", r_paddr, 32'h0ABCD456);
        chk("R11", "one response", done_cnt - d0, 1);
        chk("R11", "two reads", rd_cnt - rd0, 2);
    endtask

    task automatic t_root();
        poke(32'h4014, 32'h00002027);
        @(negedge clk);
        root_we = 1'b1; root_frame = 20'h00004;
        @(negedge clk);
        root_we = 1'b0;
        walk(VA1, 1'b0, 1'b0);
        chk("R13", "dir addr", rd_log[rd0 & 7], 32'h00004014);
        chk("R13", "paddr", r_paddr, 32'h0ABCD456);
    endtask

    initial begin
        for (int i = 0; i < 8192; i++) mem[i] = 32'h0;
        mem[32'h1014 >> 2] = 32'h00002007;
        mem[32'h201C >> 2] = 32'h0ABCD007;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        root_we = 1'b1; root_frame = 20'h00001;
        @(negedge clk);
        root_we = 1'b0;
        t_first_read();
        t_repeat();
        t_dirty();
        t_not_present();
        t_user();
        t_write_perm();
        t_supervisor();
        t_busy();
        t_root();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule